// File: doc/BRIEF.md
# Priority Pending Interrupt Selector

This block decides, for every processor in a cluster, which interrupt source should be offered to it next and whether that processor's interrupt request line should be raised. Each processor has its own slice. The slice looks at every source whose enable bit and pending bit are both set for that processor, and picks the one with the most urgent priority. A numerically smaller 8-bit priority value is more urgent.

Two thresholds are then applied to the winner. The processor's priority mask decides whether the winner's ID is reported at all. If the winner is masked, or if nothing qualifies, the reserved ID 1023 is reported. The processor's running priority decides whether the request line is raised for a reported winner. The running priority is 9 bits wide, and the value 0x100 marks an idle processor. A global enable and a per-processor enable can each force that processor to report 1023 with its line low.

The block is purely combinational, so its outputs follow any input change within the same cycle. It is intended to sit between the state registers of an interrupt distributor and the request pins of the processors.

Top module: `ppis_top`

## Requirements
- R1: Among the sources that qualify for a processor, the one with the numerically lowest priority value is selected.
- R2: When qualifying sources share the lowest priority value, the one with the smallest source index is selected.
- R3: Source i qualifies for processor c only when both enable bit c*NUM_IRQ+i and pending bit c*NUM_IRQ+i are set. A source with only one of the two bits set has no effect on that processor's outputs.
- R4: When no source qualifies for a processor, its reported ID (bits 10c+9..10c of `pend_id`) is 1023 and its request line is low.
- R5: When `dist_en` is low, or bit c of `cpu_en` is low, processor c reports ID 1023 with its request line low, whatever the sources are doing.
- R6: The winner's ID is reported only when its priority is strictly less than the processor's mask (bits 8c+7..8c of `prio_mask`). A priority equal to or above the mask gives ID 1023 and a low request line.
- R7: For a reported winner, the request line is high only when its priority is strictly less than the processor's running priority (bits 9c+8..9c of `run_prio`). Otherwise the ID is still reported, but the line stays low.
- R8: A running priority of 0x100 lets any unmasked winner, including priority 0xFE, raise the request line.
- R9: Each processor's outputs depend only on its own enable bits, pending bits, enable, mask and running priority. The priority of source i (bits 8i+7..8i of `src_prio`) is shared by all processors.
- R10: The outputs change in the same cycle as the inputs, with no clocked stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dist_en | input | 1 | Global enable for all processors |
| cpu_en | input | NUM_CPU | Per-processor enable |
| src_enable | input | NUM_CPU*NUM_IRQ | Enable bit of source i for processor c, at bit c*NUM_IRQ+i |
| src_pending | input | NUM_CPU*NUM_IRQ | Pending bit of source i for processor c, at bit c*NUM_IRQ+i |
| src_prio | input | NUM_IRQ*8 | 8-bit priority of each source; lower is more urgent |
| prio_mask | input | NUM_CPU*8 | Per-processor priority mask |
| run_prio | input | NUM_CPU*9 | Per-processor running priority; 0x100 means idle |
| irq_req | output | NUM_CPU | Per-processor interrupt request line |
| pend_id | output | NUM_CPU*10 | Per-processor highest pending ID; 1023 when there is none |

## Verification
The bench goes after the two strict comparisons. It checks a winner whose priority equals the mask, and a winner whose priority equals the running priority. A design that used less-or-equal would report the masked ID in the first case, or raise the line during equal-priority handling in the second. Priority ties are placed with the higher-index source listed first in the stimulus, so a tree that preferred its right operand on equality would return the wrong ID. Half-qualified sources, which have only an enable bit or only a pending bit, are given the most urgent priority. Any leak in the qualification logic therefore shows up directly as a wrong winner. A second processor is driven with its own sources, which exposes slices that share or cross their per-processor bits.

// File: rtl/ppis_pkg.sv
package ppis_pkg;

  localparam int PRIO_W = 8;
  localparam int RUN_W  = PRIO_W + 1;
  localparam int ID_W   = 10;

  localparam logic [ID_W-1:0]  NO_IRQ    = 10'd1023;
  localparam logic [RUN_W-1:0] IDLE_PRIO = 9'h100;

  typedef struct packed {
    logic [RUN_W-1:0] prio;
    logic [ID_W-1:0]  id;
  } cand_t;

  localparam cand_t EMPTY_CAND = '{prio: IDLE_PRIO, id: NO_IRQ};

endpackage

// File: rtl/ppis_min_tree.sv
module ppis_min_tree
  import ppis_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic [NUM_IRQ-1:0]        valid,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio,
  output cand_t                     best
);

  localparam int LVL    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int LEAVES = 1 << LVL;
  localparam int NODES  = 2 * LEAVES;

  cand_t node [1:NODES-1];

  // Heap-indexed tree: leaves at LEAVES+i, parent k combines 2k and 2k+1.
  // On equal priority the left (lower index) child is kept.
  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (valid[i]) begin
        node[LEAVES+i].prio = {1'b0, prio[i*PRIO_W +: PRIO_W]};
        node[LEAVES+i].id   = ID_W'(i);
      end else begin
        node[LEAVES+i] = EMPTY_CAND;
      end
    end
    for (int i = NUM_IRQ; i < LEAVES; i++) begin
      node[LEAVES+i] = EMPTY_CAND;
    end
    for (int k = LEAVES - 1; k >= 1; k--) begin
      if (node[2*k+1].prio < node[2*k].prio) node[k] = node[2*k+1];
      else                                   node[k] = node[2*k];
    end
  end

  assign best = node[1];

  always_comb begin
    // R4
    empty_match_chk: assert ((|valid) == (best.prio != IDLE_PRIO))
      else $error("tree: empty flag and result priority disagree");
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (valid[i]) begin
        // R1
        min_bound_chk: assert (best.prio <= {1'b0, prio[i*PRIO_W +: PRIO_W]})
          else $error("tree: result priority above a qualifying source");
        // R2
        tie_low_chk: assert (best.prio != {1'b0, prio[i*PRIO_W +: PRIO_W]} ||
                             best.id <= ID_W'(i))
          else $error("tree: tie not resolved to the lowest index");
      end
    end
  end

endmodule

// File: rtl/ppis_cpu_gate.sv
module ppis_cpu_gate
  import ppis_pkg::*;
(
  input  logic              dist_en,
  input  logic              cpu_en,
  input  logic [PRIO_W-1:0] mask,
  input  logic [RUN_W-1:0]  run,
  input  cand_t             best,
  output logic              req,
  output logic [ID_W-1:0]   id
);

  logic on;
  logic unmasked;

  assign on       = dist_en & cpu_en;
  assign unmasked = best.prio < {1'b0, mask};

  always_comb begin
    req = 1'b0;
    id  = NO_IRQ;
    if (on && unmasked) begin
      id  = best.id;
      req = best.prio < run;
    end
  end

  always_comb begin
    // R7
    req_has_id_chk: assert (!req || id != NO_IRQ)
      else $error("gate: request raised without an ID");
    // R7
    req_below_run_chk: assert (!req || best.prio < run)
      else $error("gate: request with priority not below running priority");
    // R6
    id_below_mask_chk: assert (id == NO_IRQ || (id == best.id && best.prio < {1'b0, mask}))
      else $error("gate: reported ID not the unmasked winner");
    // R5
    off_quiet_chk: assert ((dist_en && cpu_en) || (!req && id == NO_IRQ))
      else $error("gate: disabled processor still active");
  end

endmodule

// File: rtl/ppis_top.sv
module ppis_top
  import ppis_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                        dist_en,
  input  logic [NUM_CPU-1:0]          cpu_en,
  input  logic [NUM_CPU*NUM_IRQ-1:0]  src_enable,
  input  logic [NUM_CPU*NUM_IRQ-1:0]  src_pending,
  input  logic [NUM_IRQ*PRIO_W-1:0]   src_prio,
  input  logic [NUM_CPU*PRIO_W-1:0]   prio_mask,
  input  logic [NUM_CPU*RUN_W-1:0]    run_prio,
  output logic [NUM_CPU-1:0]          irq_req,
  output logic [NUM_CPU*ID_W-1:0]     pend_id
);

  genvar c;
  generate
    for (c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NUM_IRQ-1:0] qual;
      cand_t              best;

      // R3: a source takes part only with both bits set for this processor
      assign qual = src_enable[c*NUM_IRQ +: NUM_IRQ] & src_pending[c*NUM_IRQ +: NUM_IRQ];

      ppis_min_tree #(.NUM_IRQ(NUM_IRQ)) u_tree (
        .valid (qual),
        .prio  (src_prio),
        .best  (best)
      );

      ppis_cpu_gate u_gate (
        .dist_en (dist_en),
        .cpu_en  (cpu_en[c]),
        .mask    (prio_mask[c*PRIO_W +: PRIO_W]),
        .run     (run_prio[c*RUN_W +: RUN_W]),
        .best    (best),
        .req     (irq_req[c]),
        .id      (pend_id[c*ID_W +: ID_W])
      );

      always_comb begin
        // R3
        no_qual_quiet_chk: assert ((|qual) || (!irq_req[c] && pend_id[c*ID_W +: ID_W] == NO_IRQ))
          else $error("top: output active with no qualifying source");
      end
    end
  endgenerate

endmodule

// File: tb/ppis_top_test.sv
module ppis_top_test;

  localparam int NI = 64;
  localparam int NC = 2;

  logic           clk;
  logic           dist_en;
  logic [NC-1:0]  cpu_en;
  logic [NC*NI-1:0] src_enable, src_pending;
  logic [NI*8-1:0]  src_prio;
  logic [NC*8-1:0]  prio_mask;
  logic [NC*9-1:0]  run_prio;
  logic [NC-1:0]    irq_req;
  logic [NC*10-1:0] pend_id;

  int n_chk = 0;
  int n_bad = 0;

  ppis_top #(.NUM_IRQ(NI), .NUM_CPU(NC)) uut (
    .dist_en(dist_en), .cpu_en(cpu_en), .src_enable(src_enable),
    .src_pending(src_pending), .src_prio(src_prio), .prio_mask(prio_mask),
    .run_prio(run_prio), .irq_req(irq_req), .pend_id(pend_id)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [6:0] a_id;
    logic [7:0] a_pr;
    logic       b_v;
    logic [6:0] b_id;
    logic [7:0] b_pr;
    logic [7:0] mask;
    logic [8:0] run;
    logic [9:0] exp_id;
    logic       exp_req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t [0:NV-1] TBL = '{
    '{7'd5,  8'h40, 1'b1, 7'd9,  8'h20, 8'hFF, 9'h100, 10'd9,    1'b1}, // R1
    '{7'd7,  8'h30, 1'b1, 7'd3,  8'h30, 8'hFF, 9'h100, 10'd3,    1'b1}, // R2
    '{7'd40, 8'h10, 1'b1, 7'd12, 8'h10, 8'hFF, 9'h100, 10'd12,   1'b1}, // R2
    '{7'd2,  8'h50, 1'b0, 7'd0,  8'h00, 8'h50, 9'h100, 10'd1023, 1'b0}, // R6 equal
    '{7'd2,  8'h4F, 1'b0, 7'd0,  8'h00, 8'h50, 9'h100, 10'd2,    1'b1}, // R6 below
    '{7'd2,  8'h40, 1'b0, 7'd0,  8'h00, 8'hFF, 9'h040, 10'd2,    1'b0}, // R7 equal
    '{7'd2,  8'h40, 1'b0, 7'd0,  8'h00, 8'hFF, 9'h041, 10'd2,    1'b1}, // R7 below
    '{7'd63, 8'hFE, 1'b0, 7'd0,  8'h00, 8'hFF, 9'h100, 10'd63,   1'b1}, // R8
    '{7'd0,  8'h00, 1'b0, 7'd0,  8'h00, 8'hFF, 9'h000, 10'd0,    1'b0}, // R7 zero run
    '{7'd20, 8'h80, 1'b1, 7'd21, 8'h7F, 8'h80, 9'h100, 10'd21,   1'b1}  // R1 R6
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    dist_en     = 1'b1;
    cpu_en      = '1;
    src_enable  = '0;
    src_pending = '0;
    src_prio    = '0;
    prio_mask   = {NC{8'hFF}};
    run_prio    = {NC{9'h100}};
  endtask

  task automatic qualify(input int cpu, input int src, input logic [7:0] pr);
    src_enable[cpu*NI+src]  = 1'b1;
    src_pending[cpu*NI+src] = 1'b1;
    src_prio[src*8 +: 8]    = pr;
  endtask

  function automatic int id_of(input int cpu);
    return int'(pend_id[cpu*10 +: 10]);
  endfunction

  // Drive just after a rising edge, sample mid-cycle.
  task automatic settle();
    @(posedge clk);
    #5;
  endtask

  initial begin
    clear_all();
    cpu_en = '0;
    dist_en = 1'b0;
    settle();
    // R4 / R5: idle state after power-up
    chk("R4 idle id cpu0", id_of(0), 1023);
    chk("R4 idle req cpu0", int'(irq_req[0]), 0);
    chk("R4 idle id cpu1", id_of(1), 1023);

    // Table walk on processor 0; processor 1 left without sources (R9)
    for (int v = 0; v < NV; v++) begin
      @(posedge clk);
      clear_all();
      qualify(0, int'(TBL[v].a_id), TBL[v].a_pr);
      if (TBL[v].b_v) qualify(0, int'(TBL[v].b_id), TBL[v].b_pr);
      prio_mask[7:0] = TBL[v].mask;
      run_prio[8:0]  = TBL[v].run;
      #5;
      chk($sformatf("R1/R2/R6/R7/R8 vec%0d id", v), id_of(0), int'(TBL[v].exp_id));
      chk($sformatf("R1/R2/R6/R7/R8 vec%0d req", v), int'(irq_req[0]), int'(TBL[v].exp_req));
      chk($sformatf("R9 vec%0d cpu1 id", v), id_of(1), 1023);
    end

    // R3: half-qualified sources with the most urgent priority are ignored
    @(posedge clk);
    clear_all();
    qualify(0, 30, 8'h60);
    src_enable[0*NI+4]   = 1'b1; src_prio[4*8 +: 8] = 8'h00;
    src_pending[0*NI+5]  = 1'b1; src_prio[5*8 +: 8] = 8'h00;
    #5;
    chk("R3 half-qualified ignored id", id_of(0), 30);
    chk("R3 half-qualified ignored req", int'(irq_req[0]), 1);
    src_pending[0*NI+30] = 1'b0;
    #5;
    chk("R3 enable-only leaves nothing", id_of(0), 1023);
    chk("R4 nothing qualifies req", int'(irq_req[0]), 0);

    // R5: global enable and per-processor enable
    @(posedge clk);
    clear_all();
    qualify(0, 8, 8'h10);
    qualify(1, 8, 8'h10);
    dist_en = 1'b0;
    #5;
    chk("R5 global off id cpu0", id_of(0), 1023);
    chk("R5 global off req cpu1", int'(irq_req[1]), 0);
    dist_en = 1'b1;
    cpu_en  = 2'b10;
    #5;
    chk("R5 cpu0 off id", id_of(0), 1023);
    chk("R5 cpu0 off req", int'(irq_req[0]), 0);
    chk("R5 cpu1 still on id", id_of(1), 8);

    // R9: independent processors with their own thresholds
    @(posedge clk);
    clear_all();
    qualify(1, 10, 8'h20);
    qualify(0, 11, 8'h30);
    run_prio[9 +: 9] = 9'h020;
    #5;
    chk("R9 cpu0 id", id_of(0), 11);
    chk("R9 cpu0 req", int'(irq_req[0]), 1);
    chk("R9 cpu1 id", id_of(1), 10);
    chk("R9 cpu1 req blocked by own run", int'(irq_req[1]), 0);

    // R10: change without any clock edge, output follows within the cycle
    @(posedge clk);
    #3;
    src_pending[0*NI+11] = 1'b0;
    #1;
    chk("R10 same-cycle id update", id_of(0), 1023);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule